// File: doc/BRIEF.md
# Bridge System Error Reporter

This block decides when a two-sided bus bridge raises its active-low primary system error line. It watches five kinds of events:
- data parity error reports, each tagged with transaction kind, direction and detecting side;
- the secondary side's active-low system error input;
- target-abort and master-abort strobes for posted writes;
- a per-posted-write retry tracker that gives up after a fixed power-of-two number of target retries.

Each event that qualifies drives the line low for one clock. Software-visible enables are held in a small configuration register loaded through a write strobe. Two sticky status flags record that the line was driven and that a secondary system error was received. Software clears a flag by writing a one to its position.

All inputs are single-cycle control strobes or levels with no back-pressure. An event is sampled on a clock edge and shows on the outputs right after that edge. Nothing is buffered, so an event that is not qualified in its own cycle is lost.

Top module: `bridge_serr_reporter`

## Requirements
- R1: The output `pri_serr_n` is never driven low, and the signaled flag is never set, while the system-error enable (config bit 0) is clear.
- R2: After reset `pri_serr_n` is 1, both status flags are 0 and `pw_discard` is 0. Each cycle that holds at least one qualifying event drives `pri_serr_n` low for exactly the following clock. At all other times it stays 1.
- R3: Whenever `pri_serr_n` is low, the signaled flag (`sts_flags[0]`) is set in that same cycle.
- R4: A high-to-low transition of `sec_serr_n` with forward enable (config bit 3) set does two things. It sets the received flag (`sts_flags[1]`). It also counts as a qualifying event, gated by R1. Holding `sec_serr_n` low does not repeat the event. With forward enable clear, the transition has no effect.
- R5: A parity report qualifies only when all of the following hold: the kind is posted write (kind code 2'b01); the direction and side are either downstream (dir 0) seen on the secondary side (side 1), or upstream (dir 1) seen on the primary side (side 0); and both parity-response enables (config bits 1 and 2) are set.
- R6: Parity reports for read (2'b00), delayed write (2'b10) or reserved (2'b11) kinds never qualify. The same holds for posted writes seen on the initiator side, and for any report while either parity-response enable is clear.
- R7: A `pw_tgt_abort` or `pw_mst_abort` strobe is a qualifying event.
- R8: `pw_start` clears the retry count and arms the tracker. It wins over a `pw_retry` in the same cycle. The 2^RETRY_W-th retry after a start does three things: it pulses `pw_discard` for one clock, it counts as a qualifying event, and it disarms the tracker. Retries while the tracker is disarmed are ignored.
- R9: The status flags are sticky. A cycle with `sts_clr` high clears each flag whose `sts_clr_mask` bit is 1, taking effect the next cycle. If a flag is set in the same cycle it is cleared, the set wins.
- R10: `cfg_we` loads `cfg_wdata` into the enables: bit 0 system-error enable, bit 1 primary parity response, bit 2 secondary parity response, bit 3 forward enable. The new values apply from the following cycle, so an event in the write cycle sees the old ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load enables from cfg_wdata |
| cfg_wdata | input | 4 | Enable values (see R10) |
| par_valid | input | 1 | Parity error report strobe |
| par_kind | input | 2 | Transaction kind code |
| par_dir | input | 1 | 0 downstream, 1 upstream |
| par_side | input | 1 | Detecting side: 0 primary, 1 secondary |
| sec_serr_n | input | 1 | Secondary system error, active low |
| pw_tgt_abort | input | 1 | Target abort on a posted write |
| pw_mst_abort | input | 1 | Master abort on a posted write |
| pw_start | input | 1 | New posted write begins delivery |
| pw_retry | input | 1 | Target retry response for the posted write |
| sts_clr | input | 1 | Write-one-to-clear strobe for status |
| sts_clr_mask | input | 2 | Flags to clear |
| pri_serr_n | output | 1 | Primary system error, active low, open-drain style |
| pw_discard | output | 1 | One-clock pulse when a posted write is discarded |
| sts_flags | output | 2 | Bit 0 signaled, bit 1 received |

## Verification
The parity qualifier is swept over all 64 combinations of kind, direction, side and the two parity-response enables. This separates the two qualifying posted-write cases from the initiator-side, read, delayed-write and reserved cases. Each source is then replayed with the system-error enable off, which tells the gate apart from the qualifiers. The secondary input is held low for several cycles to tell edge detection from level detection. The retry tracker is run to exactly its limit, past it, and through a restart that coincides with a retry, which exposes off-by-one errors and a wrong start/retry priority. Same-cycle set/clear of the status flags and same-cycle configuration writes pin down the priority rules.

// File: rtl/serr_pkg.sv
package serr_pkg;
  typedef enum logic [1:0] {
    KIND_READ    = 2'b00,
    KIND_POSTED  = 2'b01,
    KIND_DELAYED = 2'b10,
    KIND_RSVD    = 2'b11
  } txn_kind_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } txn_dir_e;

  typedef enum logic {
    SIDE_PRI = 1'b0,
    SIDE_SEC = 1'b1
  } bus_side_e;

  localparam int CFG_W = 4;
  localparam int STS_W = 2;
  localparam int STS_SIG = 0;
  localparam int STS_RCV = 1;

  typedef struct packed {
    logic fwd_en;
    logic perr_sec;
    logic perr_pri;
    logic serr_en;
  } cfg_t;
endpackage

// File: rtl/serr_parity_qual.sv
module serr_parity_qual
  import serr_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] kind,
  input  logic       dir,
  input  logic       side,
  input  logic       perr_pri,
  input  logic       perr_sec,
  output logic       hit
);
  logic is_posted;
  logic target_side;

  always_comb begin
    is_posted   = (kind == KIND_POSTED);
    // the error must be seen on the bus the write was delivered to
    target_side = ((dir == DIR_DOWN) && (side == SIDE_SEC)) ||
                  ((dir == DIR_UP)   && (side == SIDE_PRI));
    hit         = valid && is_posted && target_side && perr_pri && perr_sec;
  end
endmodule

// File: rtl/serr_retry_tracker.sv
module serr_retry_tracker #(
  parameter int CNT_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic retry,
  output logic exhaust,
  output logic discard
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [CNT_W-1:0] cnt;
  logic             armed;

  assign exhaust = armed && retry && !start && (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      discard <= 1'b0;
    end else begin
      discard <= exhaust;
      if (start) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (exhaust) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else if (armed && retry) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_discard_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !discard);
  assert_start_rearms_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (armed && cnt == '0));
  assert_idle_no_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !start) |=> $stable(cnt));
endmodule

// File: rtl/serr_status_bits.sv
module serr_status_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                  q[i] <= 1'b0;
      else if (set[i])             q[i] <= 1'b1;
      else if (clr && clr_mask[i]) q[i] <= 1'b0;
    end

    assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && clr_mask[i] && !set[i]) |=> !q[i]);
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/bridge_serr_reporter.sv
module bridge_serr_reporter
  import serr_pkg::*;
#(
  parameter int RETRY_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             par_valid,
  input  logic [1:0]       par_kind,
  input  logic             par_dir,
  input  logic             par_side,
  input  logic             sec_serr_n,
  input  logic             pw_tgt_abort,
  input  logic             pw_mst_abort,
  input  logic             pw_start,
  input  logic             pw_retry,
  input  logic             sts_clr,
  input  logic [STS_W-1:0] sts_clr_mask,
  output logic             pri_serr_n,
  output logic             pw_discard,
  output logic [STS_W-1:0] sts_flags
);
  cfg_t             cfg_q;
  logic             par_hit;
  logic             retry_exhaust;
  logic             sec_prev;
  logic             sec_fall;
  logic             fwd_hit;
  logic             any_event;
  logic             drive_now;
  logic [STS_W-1:0] sts_set;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
  end

  serr_parity_qual u_par (
    .valid    (par_valid),
    .kind     (par_kind),
    .dir      (par_dir),
    .side     (par_side),
    .perr_pri (cfg_q.perr_pri),
    .perr_sec (cfg_q.perr_sec),
    .hit      (par_hit)
  );

  serr_retry_tracker #(.CNT_W(RETRY_W)) u_retry (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (pw_start),
    .retry   (pw_retry),
    .exhaust (retry_exhaust),
    .discard (pw_discard)
  );

  // secondary input is forwarded on its falling edge only
  always_ff @(posedge clk) begin
    if (!rst_n) sec_prev <= 1'b1;
    else        sec_prev <= sec_serr_n;
  end

  always_comb begin
    sec_fall  = sec_prev && !sec_serr_n;
    fwd_hit   = sec_fall && cfg_q.fwd_en;
    any_event = par_hit || fwd_hit || pw_tgt_abort || pw_mst_abort || retry_exhaust;
    drive_now = any_event && cfg_q.serr_en;
    sts_set          = '0;
    sts_set[STS_SIG] = drive_now;
    sts_set[STS_RCV] = fwd_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pri_serr_n <= 1'b1;
    else        pri_serr_n <= !drive_now;
  end

  serr_status_bits #(.N(STS_W)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (sts_set),
    .clr      (sts_clr),
    .clr_mask (sts_clr_mask),
    .q        (sts_flags)
  );

  assert_enable_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> $past(cfg_q.serr_en));
  assert_signaled_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_serr_n |-> sts_flags[STS_SIG]);
  assert_rcv_needs_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_flags[STS_RCV]) |-> $past(cfg_q.fwd_en));
  assert_quiet_no_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_valid && sec_serr_n && !pw_tgt_abort && !pw_mst_abort && !pw_retry) |=> pri_serr_n);
  assert_nonposted_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (par_valid && par_kind != KIND_POSTED && sec_serr_n && !pw_tgt_abort &&
     !pw_mst_abort && !pw_retry) |=> pri_serr_n);
endmodule

// File: tb/test_bridge_serr_reporter.sv
module test_bridge_serr_reporter;
  localparam int RW = 3;
  localparam int LIMIT = 1 << RW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic       par_valid = 1'b0;
  logic [1:0] par_kind = '0;
  logic       par_dir = 1'b0;
  logic       par_side = 1'b0;
  logic       sec_serr_n = 1'b1;
  logic       pw_tgt_abort = 1'b0;
  logic       pw_mst_abort = 1'b0;
  logic       pw_start = 1'b0;
  logic       pw_retry = 1'b0;
  logic       sts_clr = 1'b0;
  logic [1:0] sts_clr_mask = '0;
  logic       pri_serr_n;
  logic       pw_discard;
  logic [1:0] sts_flags;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bridge_serr_reporter #(.RETRY_W(RW)) i_bridge_serr_reporter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .par_valid(par_valid), .par_kind(par_kind), .par_dir(par_dir), .par_side(par_side),
    .sec_serr_n(sec_serr_n), .pw_tgt_abort(pw_tgt_abort), .pw_mst_abort(pw_mst_abort),
    .pw_start(pw_start), .pw_retry(pw_retry), .sts_clr(sts_clr), .sts_clr_mask(sts_clr_mask),
    .pri_serr_n(pri_serr_n), .pw_discard(pw_discard), .sts_flags(sts_flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 0; par_valid = 0; pw_tgt_abort = 0; pw_mst_abort = 0;
    pw_start = 0; pw_retry = 0; sts_clr = 0; sts_clr_mask = '0;
  endtask

  // inputs were driven at a negedge; advance one cycle, idle inputs
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic write_cfg(input logic [3:0] v);
    cfg_we = 1; cfg_wdata = v;
    step();
  endtask

  task automatic clear_sts();
    sts_clr = 1; sts_clr_mask = 2'b11;
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R2 reset serr", int'(pri_serr_n), 1);
    chk("R2 reset flags", int'(sts_flags), 0);
    chk("R2 reset discard", int'(pw_discard), 0);

    // R5 / R6 exhaustive parity sweep
    for (int pe = 0; pe < 4; pe++) begin
      write_cfg({1'b1, pe[1], pe[0], 1'b1});
      for (int k = 0; k < 4; k++)
        for (int d = 0; d < 2; d++)
          for (int s = 0; s < 2; s++) begin
            automatic bit exp = (k == 1) && ((d == 0 && s == 1) || (d == 1 && s == 0)) &&
                                (pe == 3);
            par_valid = 1; par_kind = k[1:0]; par_dir = d[0]; par_side = s[0];
            step();
            chk(exp ? "R5 parity qualifies" : "R6 parity ignored", int'(pri_serr_n), exp ? 0 : 1);
            chk("R3 signaled flag", int'(sts_flags[0]), exp ? 1 : 0);
            clear_sts();
            chk("R2 released", int'(pri_serr_n), 1);
            chk("R9 cleared", int'(sts_flags), 0);
          end
    end

    // R1 enable off
    write_cfg(4'b1110);
    par_valid = 1; par_kind = 2'b01; par_dir = 0; par_side = 1;
    step();
    chk("R1 parity gated", int'(pri_serr_n), 1);
    pw_tgt_abort = 1;
    step();
    chk("R1 abort gated", int'(pri_serr_n), 1);
    chk("R1 no signaled", int'(sts_flags[0]), 0);

    // R10 write in same cycle as event uses old enables
    cfg_we = 1; cfg_wdata = 4'b1111; pw_mst_abort = 1;
    step();
    chk("R10 old enable used", int'(pri_serr_n), 1);
    pw_mst_abort = 1;
    step();
    chk("R10 new enable applies", int'(pri_serr_n), 0);
    clear_sts();

    // R7 each abort, R2 back-to-back events
    pw_tgt_abort = 1;
    step();
    chk("R7 target abort", int'(pri_serr_n), 0);
    step();
    chk("R2 one clock", int'(pri_serr_n), 1);
    pw_mst_abort = 1;
    @(negedge clk);
    chk("R7 master abort", int'(pri_serr_n), 0);
    step();
    chk("R2 consecutive low", int'(pri_serr_n), 0);
    step();
    chk("R2 released after two", int'(pri_serr_n), 1);
    clear_sts();

    // R4 secondary forwarding, held low three cycles
    sec_serr_n = 0;
    step();
    chk("R4 forwarded", int'(pri_serr_n), 0);
    chk("R4 received flag", int'(sts_flags[1]), 1);
    step();
    chk("R4 level not repeated", int'(pri_serr_n), 1);
    step();
    chk("R4 still quiet", int'(pri_serr_n), 1);
    sec_serr_n = 1;
    step();
    clear_sts();
    write_cfg(4'b0111);
    sec_serr_n = 0;
    step();
    chk("R4 fwd off no drive", int'(pri_serr_n), 1);
    chk("R4 fwd off no flag", int'(sts_flags), 0);
    sec_serr_n = 1;
    step();
    write_cfg(4'b1000);
    sec_serr_n = 0;
    step();
    chk("R1 fwd but disabled", int'(pri_serr_n), 1);
    chk("R4 received w/o enable", int'(sts_flags), 2);
    sec_serr_n = 1;
    step();
    clear_sts();

    // R9 set wins over clear; mask selects bits
    write_cfg(4'b1111);
    sec_serr_n = 0;
    step();
    sec_serr_n = 1;
    chk("R9 both set", int'(sts_flags), 3);
    sts_clr = 1; sts_clr_mask = 2'b10;
    step();
    chk("R9 masked clear", int'(sts_flags), 1);
    sts_clr = 1; sts_clr_mask = 2'b01; pw_tgt_abort = 1;
    step();
    chk("R9 set wins", int'(sts_flags), 1);
    clear_sts();

    // R8 retry tracker
    pw_retry = 1;
    step();
    chk("R8 disarmed retry ignored", int'(pw_discard), 0);
    pw_start = 1;
    step();
    for (int i = 1; i < LIMIT; i++) begin
      pw_retry = 1;
      step();
      chk("R8 below limit", int'(pw_discard), 0);
      chk("R8 below limit serr", int'(pri_serr_n), 1);
    end
    pw_retry = 1;
    step();
    chk("R8 discard pulse", int'(pw_discard), 1);
    chk("R8 discard serr", int'(pri_serr_n), 0);
    pw_retry = 1;
    step();
    chk("R8 pulse one clock", int'(pw_discard), 0);
    for (int i = 0; i < LIMIT + 2; i++) begin
      pw_retry = 1;
      step();
      chk("R8 disarmed after discard", int'(pw_discard), 0);
    end
    pw_start = 1;
    step();
    for (int i = 0; i < 5; i++) begin pw_retry = 1; step(); end
    pw_start = 1; pw_retry = 1;
    step();
    for (int i = 1; i < LIMIT; i++) begin
      pw_retry = 1;
      step();
      chk("R8 start wins", int'(pw_discard), 0);
    end
    pw_retry = 1;
    step();
    chk("R8 limit after restart", int'(pw_discard), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule